// File: doc/BRIEF.md
# Spaced-Seed Index Table Builder

This block builds a seed index over a reference sequence held in external memory. It takes a stream of 2-bit nucleotide codes, one per accepted transfer, each tagged with its position in the reference. It keeps a sliding window of the most recent characters. A fixed spaced mask picks some window positions, and the picked characters are packed into a seed.

Each seed selects a slot in the index memory. A slot is one count word followed by `MAX_ENTRIES` position words. For each seed, a short sequencer reads the slot's count and writes back the count plus one. It then appends the character's reference position at the array element the old count points to. A slot that is already full is left unchanged, and a sticky saturation flag is raised.

The input stream stalls while a sequence is in progress. The memory port issues single-word requests that the memory always accepts. Read data comes back with `mem_rvalid` after any latency.

Top module: `spaced_seed_indexer`

## Requirements
- R1: While no memory sequence is pending, `in_ready` is high and one character is accepted on every clock that `in_valid` is high.
- R2: No memory request is issued until `SPAN` characters have been accepted since reset.
- R3: The count read is issued in the cycle after a character whose seed is due has been accepted. `in_ready` stays low from that read until the sequence has finished.
- R4: Characters use the codes A=00, C=01, G=10 and T=11. Mask bit j selects the character accepted j transfers before the newest one, so bit 0 selects the newest. The selected characters are packed with the smallest j in seed bits [1:0]. The count read goes to address seed*(MAX_ENTRIES+1).
- R5: When the count read returns L < `MAX_ENTRIES`, the block writes L+1 to the slot base. In the next cycle it writes the character's position to base+1+L. After that `in_ready` returns high.
- R6: When the count read returns L >= `MAX_ENTRIES`, nothing is written. `sat_flag` is set and stays set until reset.
- R7: The sequencer waits any number of cycles for `mem_rvalid` before it acts on `mem_rdata`.
- R8: After reset `in_ready` is 1, `mem_req` is 0, `sat_flag` is 0, and the window is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Character available |
| in_ready | output | 1 | Block can take a character |
| in_char | input | 2 | Nucleotide code |
| in_pos | input | 32 | Reference position of the character |
| mem_req | output | 1 | Memory request this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data |
| mem_rvalid | input | 1 | Read data valid |
| sat_flag | output | 1 | Sticky: an append was refused because a slot was full |

## Verification
The cycle in which the count response arrives decides between two functions: appending to the slot or refusing and raising saturation. The bench provokes both outcomes on the same slot. After a reset it streams identical characters, so seed 0 recurs until the slot holds `MAX_ENTRIES` positions. It then sends one more identical character. The bench judges the result at the ports: either a count write and a position write at the computed addresses, or no write with the flag set. A following append to a different slot shows that the flag stays set. The vector walk runs once with a one-cycle response latency and once with a longer latency, so the wait for read data is exercised both ways.

// File: rtl/spaced_seed_indexer.sv
module spaced_seed_indexer #(
  parameter int SPAN = 5,
  parameter logic [SPAN-1:0] MASK = 5'b11011,
  parameter int MAX_ENTRIES = 3,
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [1:0]        in_char,
  input  logic [31:0]       in_pos,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_rvalid,
  output logic              sat_flag
);

  function automatic int count_ones(input logic [SPAN-1:0] m);
    int c;
    c = 0;
    for (int i = 0; i < SPAN; i++) c += int'(m[i]);
    return c;
  endfunction

  localparam int K      = count_ones(MASK);
  localparam int SEED_W = 2 * K;
  localparam int STRIDE = MAX_ENTRIES + 1;
  localparam int FILL_W = $clog2(SPAN + 1);

  typedef enum logic [2:0] {S_IDLE, S_RD, S_WAIT, S_WLEN, S_WPOS} st_t;

  st_t                 st;
  logic [2*SPAN-1:0]   win;
  logic [FILL_W-1:0]   fill;
  logic [31:0]         pos_q;
  logic [31:0]         len_q;
  logic [SEED_W-1:0]   seed;
  logic [ADDR_W-1:0]   base;
  logic                accept;

  assign in_ready = (st == S_IDLE);
  assign accept   = in_valid && in_ready;

  always_comb begin
    int n;
    n = 0;
    seed = '0;
    for (int j = 0; j < SPAN; j++) begin
      if (MASK[j]) begin
        seed[2*n +: 2] = win[2*j +: 2];
        n++;
      end
    end
  end

  assign base = ADDR_W'(seed) * ADDR_W'(STRIDE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      win      <= '0;
      fill     <= '0;
      pos_q    <= '0;
      len_q    <= '0;
      sat_flag <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (accept) begin
          win   <= {win[2*SPAN-3:0], in_char};
          pos_q <= in_pos;
          if (fill != FILL_W'(SPAN)) fill <= fill + 1'b1;
          if (fill >= FILL_W'(SPAN - 1)) st <= S_RD;
        end
        S_RD: st <= S_WAIT;
        S_WAIT: if (mem_rvalid) begin
          len_q <= mem_rdata;
          if (mem_rdata >= 32'(MAX_ENTRIES)) begin
            sat_flag <= 1'b1;
            st       <= S_IDLE;
          end else begin
            st <= S_WLEN;
          end
        end
        S_WLEN: st <= S_WPOS;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = base;
    mem_wdata = '0;
    case (st)
      S_RD:   mem_req = 1'b1;
      S_WLEN: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = len_q + 32'd1;
      end
      S_WPOS: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = base + ADDR_W'(1) + ADDR_W'(len_q);
        mem_wdata = pos_q;
      end
      default: ;
    endcase
  end

  assert_read_after_accept_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req && !mem_we) |-> $past(in_valid && in_ready));

  assert_read_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we) |-> (mem_addr % ADDR_W'(STRIDE)) == '0);

  assert_len_writeback_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !$past(mem_req && mem_we))
      |-> ($past(mem_rvalid) && mem_wdata == $past(mem_rdata) + 32'd1));

  assert_pos_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && $past(mem_req && mem_we))
      |-> mem_addr == $past(mem_addr) + ADDR_W'(1) + ADDR_W'($past(mem_wdata) - 32'd1));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !$past(mem_req && mem_we)) |-> $past(mem_rdata) < 32'(MAX_ENTRIES));

  assert_sat_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sat_flag) |-> sat_flag);

endmodule

// File: tb/spaced_seed_indexer_bench.sv
module spaced_seed_indexer_bench;
  localparam int MAXE = 3;
  localparam int AW = 10;

  logic clk = 0;
  logic rst_n = 0;
  logic in_valid = 0;
  logic in_ready;
  logic [1:0] in_char = 0;
  logic [31:0] in_pos = 0;
  logic mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = 0;
  logic mem_rvalid = 0;
  logic sat_flag;

  always #4 clk = ~clk;

  spaced_seed_indexer u_spaced_seed_indexer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_char(in_char), .in_pos(in_pos), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_rvalid(mem_rvalid), .sat_flag(sat_flag));

  logic [31:0] mem_model [1024];
  int exp_len [256];
  int lat = 1;
  int cnt = 0;
  logic [AW-1:0] raddr = 0;
  int checks = 0;
  int fails = 0;

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (cnt > 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem_model[raddr];
      end
    end
    if (mem_req && !mem_we) begin
      cnt   <= lat;
      raddr <= mem_addr;
    end
    if (mem_req && mem_we) mem_model[mem_addr] <= mem_wdata;
  end

  // {char, seed due, seed}
  localparam logic [10:0] VEC [0:9] = '{
    {2'd0, 1'b0, 8'd0},   {2'd1, 1'b0, 8'd0},   {2'd2, 1'b0, 8'd0},
    {2'd3, 1'b0, 8'd0},   {2'd0, 1'b1, 8'd28},  {2'd1, 1'b1, 8'd97},
    {2'd2, 1'b1, 8'd182}, {2'd3, 1'b1, 8'd203}, {2'd3, 1'b1, 8'd31},
    {2'd2, 1'b1, 8'd110}};

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0;
    in_valid = 0;
    for (int i = 0; i < 1024; i++) mem_model[i] = 0;
    for (int i = 0; i < 256; i++) exp_len[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(in_ready == 1, "R8 ready", 32'(in_ready), 1);
    check(mem_req == 0, "R8 req", 32'(mem_req), 0);
    check(sat_flag == 0, "R8 sat", 32'(sat_flag), 0);
  endtask

  task automatic push(input logic [1:0] ch, input logic [31:0] pos, input bit has, input logic [7:0] sd);
    int guard;
    int l;
    logic [AW-1:0] b;
    b = AW'(sd) * AW'(MAXE + 1);
    @(negedge clk);
    in_valid = 1; in_char = ch; in_pos = pos;
    guard = 0;
    while (!in_ready && guard < 100) begin @(negedge clk); guard++; end
    @(negedge clk);
    in_valid = 0;
    if (!has) begin
      check(mem_req == 0, "R2 no request before fill", 32'(mem_req), 0);
      check(in_ready == 1, "R1 ready during fill", 32'(in_ready), 1);
    end else begin
      check(mem_req && !mem_we, "R3 read follows accept", 32'(mem_req), 1);
      check(mem_addr == b, "R4 seed address", 32'(mem_addr), 32'(b));
      check(in_ready == 0, "R3 ready low", 32'(in_ready), 0);
      l = exp_len[sd];
      guard = 0;
      while (!(mem_req && mem_we) && !in_ready && guard < 100) begin @(negedge clk); guard++; end
      if (l < MAXE) begin
        check(mem_req && mem_we && mem_addr == b, "R5 count write addr", 32'(mem_addr), 32'(b));
        check(mem_wdata == 32'(l + 1), "R5 count value", mem_wdata, 32'(l + 1));
        @(negedge clk);
        check(mem_req && mem_we && mem_addr == b + AW'(1 + l), "R5 position addr",
              32'(mem_addr), 32'(b) + 32'(1 + l));
        check(mem_wdata == pos, "R5 position value", mem_wdata, pos);
        exp_len[sd] = l + 1;
        @(negedge clk);
        check(in_ready == 1 && !mem_req, "R5 ready after append", 32'(in_ready), 1);
      end else begin
        check(!(mem_req && mem_we), "R6 no write when full", 32'(mem_we), 0);
        check(sat_flag == 1, "R6 saturation flag", 32'(sat_flag), 1);
      end
    end
  endtask

  task automatic fill4(input logic [1:0] c0, input logic [1:0] c1, input logic [1:0] c2, input logic [1:0] c3);
    logic [1:0] cs [4];
    cs[0] = c0; cs[1] = c1; cs[2] = c2; cs[3] = c3;
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      in_valid = 1; in_char = cs[i]; in_pos = 32'(500 + i);
      check(in_ready == 1, "R1 one char per clock", 32'(in_ready), 1);
      @(negedge clk);
      check(mem_req == 0, "R2 no request before fill", 32'(mem_req), 0);
    end
    in_valid = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R7 actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    do_reset();
    for (int i = 0; i < 10; i++)
      push(VEC[i][10:9], 32'(100 + i), VEC[i][8], VEC[i][7:0]);

    lat = 4;
    do_reset();
    for (int i = 0; i < 10; i++)
      push(VEC[i][10:9], 32'(200 + i), VEC[i][8], VEC[i][7:0]);  // R7 slow response

    lat = 1;
    do_reset();
    fill4(2'd0, 2'd1, 2'd2, 2'd3);
    push(2'd0, 32'd504, 1'b1, 8'd28);  // R4 first seed after back-to-back fill

    do_reset();
    fill4(2'd0, 2'd0, 2'd0, 2'd0);
    for (int i = 0; i < MAXE; i++) push(2'd0, 32'(300 + i), 1'b1, 8'd0);
    check(sat_flag == 0, "R6 not yet saturated", 32'(sat_flag), 0);
    check(mem_model[3] == 32'd302, "R5 last element stored", mem_model[3], 302);
    push(2'd0, 32'd399, 1'b1, 8'd0);
    check(mem_model[0] == 32'(MAXE), "R6 count unchanged", mem_model[0], 32'(MAXE));
    push(2'd1, 32'd400, 1'b1, 8'd1);
    check(sat_flag == 1, "R6 flag sticky", 32'(sat_flag), 1);
    do_reset();

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule